// File: doc/BRIEF.md
# Firmware Hub Write Cycle Target

This block is the target side of a 4-bit multiplexed firmware-hub style bus that handles memory write cycles only. It samples a nibble-wide bus and an active-low frame pin on every rising clock edge. It recognises the write start code and compares the cycle's target-select nibble with a strapped 4-bit identity. It then collects a 28-bit address, most significant nibble first, checks that the size nibble requests one byte, and assembles the data byte, least significant nibble first.

After the host's turnaround the target takes the bus for exactly two clocks, a ready sync followed by all-ones, and then releases it. A single-clock write strobe presents the decoded address and byte to the memory behind the block. A synchronous reset or an init request abandons any cycle in progress. A fresh frame assertion at any point restarts decoding.

Top module: `hubw_target`

## Requirements
- R1: While `rst` or `init` is sampled high, and on the clock that follows, `bus_oe` and `wr_stb` are 0. An `init` pulse in the middle of a cycle abandons it: no strobe and no bus drive follow it. After `rst`, `wr_addr` and `wr_data` read 0.
- R2: A cycle begins only on an edge that samples `frame_n`=0 with `bus_in`=4'b1110. Any other nibble sampled with `frame_n`=0 discards the cycle, and the target produces no strobe and no drive.
- R3: The nibble that follows the start nibble must equal `strap_id`. On a mismatch the target never drives the bus and never strobes, and it stays quiet until `frame_n` is asserted again.
- R4: The seven nibbles that follow the identity nibble form `wr_addr[27:0]`, the first received being bits 27:24 and the last bits 3:0.
- R5: The nibble that follows the address must be 4'b0000. Any other value discards the cycle with no strobe and no drive.
- R6: The two data nibbles form `wr_data`, the first received being bits 3:0 and the second bits 7:4.
- R7: `wr_strb` is named `wr_stb`. It is high for exactly one clock, in the clock period right after the edge that samples the second data nibble, with `wr_addr` and `wr_data` valid in that period.
- R8: Number the clock periods after the edge that samples the second data nibble from 1. In periods 1 and 2 `bus_oe`=0. In period 3 `bus_oe`=1 with `bus_out`=4'b0000. In period 4 `bus_oe`=1 with `bus_out`=4'b1111. From period 5 `bus_oe`=0.
- R9: `frame_n` sampled low with the start code in the middle of a cycle abandons that cycle and starts a new one at the identity nibble. Only the new cycle can produce a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising-edge sampling |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Synchronous active-high cycle abort |
| frame_n | input | 1 | Active-low cycle frame |
| bus_in | input | 4 | Nibble sampled from the bus |
| strap_id | input | 4 | Strapped identity of this target |
| bus_out | output | 4 | Nibble driven when `bus_oe` is high |
| bus_oe | output | 1 | Bus output enable, 0 means tri-state |
| wr_addr | output | 28 | Decoded write address |
| wr_data | output | 8 | Decoded write byte |
| wr_stb | output | 1 | One-clock write strobe |

## Verification
Most faults in the sequencer state or the field counter shift the target's two-clock drive window or the strobe by whole clocks. A window that moves into the host's turnaround shows as `bus_oe` high in period 1 or 2. A window that is missing or out of order shows as a wrong nibble in period 3 or 4. Both are visible within four clocks of the last data nibble. A fault in the capture path leaves the strobe on time but carries a wrong address or byte into the scoreboard comparison. A fault in the discard paths shows as an unexpected strobe or drive within a dozen clocks of the rejected nibble.

// File: rtl/hubw_pkg.sv
package hubw_pkg;

    localparam logic [3:0] START_WR  = 4'b1110;
    localparam logic [3:0] SIZE_BYTE = 4'b0000;
    localparam logic [3:0] SYNC_RDY  = 4'b0000;
    localparam logic [3:0] NIB_ONES  = 4'b1111;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID,
        ST_ADDR,
        ST_SIZE,
        ST_DATA,
        ST_TARH,
        ST_TARF,
        ST_SYNC,
        ST_DRVF,
        ST_SKIP
    } hub_state_e;

    typedef struct packed {
        logic       oe;
        logic [3:0] nib;
        logic       stb;
    } hub_out_t;

    function automatic hub_out_t out_for(hub_state_e s);
        hub_out_t o;
        o = '{oe: 1'b0, nib: NIB_ONES, stb: 1'b0};
        case (s)
            ST_TARH: o.stb = 1'b1;
            ST_SYNC: begin o.oe = 1'b1; o.nib = SYNC_RDY; end
            ST_DRVF: begin o.oe = 1'b1; o.nib = NIB_ONES; end
            default: ;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/hubw_seq.sv
module hubw_seq
    import hubw_pkg::*;
#(
    parameter int ADDR_NIBS = 7,
    parameter int DATA_NIBS = 2,
    parameter int CNT_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             frame_n,
    input  logic [3:0]       bus_in,
    input  logic [3:0]       strap_id,
    output hub_state_e       state,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBS - 1);

    hub_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = '0;
        if (!frame_n) begin
            st_d = (bus_in == START_WR) ? ST_ID : ST_IDLE;
        end else begin
            case (st_q)
                ST_ID:   st_d = (bus_in == strap_id) ? ST_ADDR : ST_SKIP;
                ST_ADDR: begin
                    if (cnt_q == ADDR_LAST) st_d = ST_SIZE;
                    else cnt_d = cnt_q + 1'b1;
                end
                ST_SIZE: st_d = (bus_in == SIZE_BYTE) ? ST_DATA : ST_SKIP;
                ST_DATA: begin
                    if (cnt_q == DATA_LAST) st_d = ST_TARH;
                    else cnt_d = cnt_q + 1'b1;
                end
                ST_TARH: st_d = ST_TARF;
                ST_TARF: st_d = ST_SYNC;
                ST_SYNC: st_d = ST_DRVF;
                ST_DRVF: st_d = ST_IDLE;
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || init) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign state = st_q;
    assign cnt   = cnt_q;

    // R3
    skip_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SKIP && frame_n && !init) |=> (st_q == ST_SKIP));

endmodule

// File: rtl/hubw_capture.sv
module hubw_capture
    import hubw_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  hub_state_e        state,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [3:0]        bus_in,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int DATA_NIBS = DATA_W / 4;

    logic [ADDR_W-1:0] addr_q;

    // address arrives most significant nibble first: shift left
    always_ff @(posedge clk) begin
        if (rst)                   addr_q <= '0;
        else if (state == ST_ADDR) addr_q <= {addr_q[ADDR_W-5:0], bus_in};
    end
    assign addr = addr_q;

    // data arrives least significant nibble first: place by counter
    for (genvar g = 0; g < DATA_NIBS; g++) begin : g_dnib
        logic [3:0] nib_q;
        always_ff @(posedge clk) begin
            if (rst)
                nib_q <= '0;
            else if (state == ST_DATA && cnt == CNT_W'(g))
                nib_q <= bus_in;
        end
        assign data[g*4 +: 4] = nib_q;
    end

endmodule

// File: rtl/hubw_drive.sv
module hubw_drive
    import hubw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       init,
    input  logic       frame_n,
    input  hub_state_e state,
    output logic       bus_oe,
    output logic [3:0] bus_out,
    output logic       wr_stb
);
    hub_out_t o;

    assign o       = out_for(state);
    assign bus_oe  = o.oe;
    assign bus_out = o.nib;
    assign wr_stb  = o.stb;

    // R8
    sync_then_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && bus_out == SYNC_RDY && frame_n && !init)
        |=> (bus_oe && bus_out == NIB_ONES));

    // R8
    turnaround_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !bus_oe);

endmodule

// File: rtl/hubw_target.sv
module hubw_target #(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              frame_n,
    input  logic [3:0]        bus_in,
    input  logic [3:0]        strap_id,
    output logic [3:0]        bus_out,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_stb
);
    import hubw_pkg::*;

    localparam int ADDR_NIBS = ADDR_W / 4;
    localparam int DATA_NIBS = DATA_W / 4;
    localparam int MAX_NIBS  = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS;
    localparam int CNT_W     = (MAX_NIBS > 1) ? $clog2(MAX_NIBS) : 1;

    hub_state_e       state;
    logic [CNT_W-1:0] cnt;

    hubw_seq #(.ADDR_NIBS(ADDR_NIBS), .DATA_NIBS(DATA_NIBS), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .init(init), .frame_n(frame_n),
        .bus_in(bus_in), .strap_id(strap_id), .state(state), .cnt(cnt)
    );

    hubw_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst(rst), .state(state), .cnt(cnt),
        .bus_in(bus_in), .addr(wr_addr), .data(wr_data)
    );

    hubw_drive u_drv (
        .clk(clk), .rst(rst), .init(init), .frame_n(frame_n), .state(state),
        .bus_oe(bus_oe), .bus_out(bus_out), .wr_stb(wr_stb)
    );

    // R7
    stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R1
    abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        init |=> (!bus_oe && !wr_stb));

    // R3
    skip_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> (!bus_oe && !wr_stb));

endmodule

// File: tb/hubw_target_tb.sv
module hubw_target_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init = 1'b0;
    logic        frame_n = 1'b1;
    logic [3:0]  bus_in = 4'hF;
    logic [3:0]  strap_id = 4'h3;
    logic [3:0]  bus_out;
    logic        bus_oe;
    logic [27:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_stb;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [35:0] exp_q[$];

    always #2 clk = ~clk;

    hubw_target u_dut (
        .clk(clk), .rst(rst), .init(init), .frame_n(frame_n), .bus_in(bus_in),
        .strap_id(strap_id), .bus_out(bus_out), .bus_oe(bus_oe),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_stb(wr_stb)
    );

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic fr, input logic [3:0] v);
        @(negedge clk);
        frame_n = fr;
        bus_in  = v;
    endtask

    // driver: sends one write cycle, queues the expected result, checks the drive window
    task automatic send(input logic [3:0] code, input logic [3:0] id, input logic [27:0] a,
                        input logic [3:0] sz, input logic [7:0] d, input bit ok, input string tag);
        if (ok) exp_q.push_back({a, d});
        step(1'b0, code);
        step(1'b1, id);
        for (int i = 6; i >= 0; i--) step(1'b1, a[i*4 +: 4]);
        step(1'b1, sz);
        step(1'b1, d[3:0]);
        step(1'b1, d[7:4]);
        step(1'b1, 4'hF); #1;
        chk(bus_oe == 1'b0, {tag, " R8 period1"}, {31'd0, bus_oe, bus_out}, 36'h0F);
        step(1'b1, 4'hF); #1;
        chk(bus_oe == 1'b0, {tag, " R8 period2"}, {31'd0, bus_oe, bus_out}, 36'h0F);
        step(1'b1, 4'hF); #1;
        if (ok) chk(bus_oe && bus_out == 4'h0, {tag, " R8 sync"}, {31'd0, bus_oe, bus_out}, 36'h10);
        else    chk(!bus_oe, {tag, " no drive"}, {31'd0, bus_oe, bus_out}, 36'h0F);
        step(1'b1, 4'hF); #1;
        if (ok) chk(bus_oe && bus_out == 4'hF, {tag, " R8 ones"}, {31'd0, bus_oe, bus_out}, 36'h1F);
        else    chk(!bus_oe, {tag, " no drive"}, {31'd0, bus_oe, bus_out}, 36'h0F);
        step(1'b1, 4'hF); #1;
        chk(!bus_oe, {tag, " R8 release"}, {31'd0, bus_oe, bus_out}, 36'h0F);
    endtask

    // monitor: pops the scoreboard on every strobe (R7)
    always @(negedge clk) begin
        if (!rst && !done && wr_stb) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected strobe", {wr_addr, wr_data}, 36'h0);
            end else begin
                logic [35:0] e;
                e = exp_q.pop_front();
                chk({wr_addr, wr_data} == e, "R4 R6 R7 addr/data", {wr_addr, wr_data}, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog act=%h exp=%h", 36'h1, 36'h0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!bus_oe && !wr_stb, "R1 reset outputs", {34'd0, bus_oe, wr_stb}, 36'h0);
        chk(wr_addr == 28'h0 && wr_data == 8'h0, "R1 reset regs", {wr_addr, wr_data}, 36'h0);
        @(negedge clk);
        rst = 1'b0;
        // start code without frame must not begin a cycle (R2)
        step(1'b1, 4'hE); step(1'b1, 4'h3);
        repeat (4) step(1'b1, 4'h0);

        send(4'hE, 4'h3, 28'h0005555, 4'h0, 8'hA0, 1'b1, "R4 R6 basic");
        send(4'hE, 4'h3, 28'hFFFFFFF, 4'h0, 8'hFF, 1'b1, "R4 ones");
        send(4'hE, 4'h3, 28'h1234567, 4'h0, 8'h3C, 1'b1, "R4 R6 order");
        send(4'hE, 4'h3, 28'h0000000, 4'h0, 8'h00, 1'b1, "R4 zeros");

        strap_id = 4'hC;
        send(4'hE, 4'h3, 28'h00ABCDE, 4'h0, 8'h55, 1'b0, "R3 mismatch");
        send(4'hE, 4'hC, 28'h00ABCDE, 4'h0, 8'h5A, 1'b1, "R3 match");

        send(4'hD, 4'hC, 28'h0111111, 4'h0, 8'h11, 1'b0, "R2 bad start");
        send(4'hE, 4'hC, 28'h0222222, 4'h1, 8'h22, 1'b0, "R5 size 1");
        send(4'hE, 4'hC, 28'h0333333, 4'h8, 8'h33, 1'b0, "R5 size 8");

        // init abort mid-address (R1)
        step(1'b0, 4'hE); step(1'b1, 4'hC);
        step(1'b1, 4'h7); step(1'b1, 4'h7); step(1'b1, 4'h7);
        @(negedge clk); init = 1'b1; bus_in = 4'h7;
        @(negedge clk); init = 1'b0; #1;
        chk(!bus_oe && !wr_stb, "R1 after init", {34'd0, bus_oe, wr_stb}, 36'h0);
        for (int i = 0; i < 10; i++) begin
            step(1'b1, 4'h0); #1;
            chk(!bus_oe, "R1 aborted cycle quiet", {35'd0, bus_oe}, 36'h0);
        end
        send(4'hE, 4'hC, 28'h0444444, 4'h0, 8'h44, 1'b1, "R1 recover");

        // frame restart mid-cycle (R9)
        step(1'b0, 4'hE); step(1'b1, 4'hC);
        step(1'b1, 4'h9); step(1'b1, 4'h9); step(1'b1, 4'h9); step(1'b1, 4'h9);
        send(4'hE, 4'hC, 28'h0FEDCBA, 4'h0, 8'h96, 1'b1, "R9 restart");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all strobes seen", 36'(exp_q.size()), 36'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule